// File: doc/BRIEF.md
# Pulse-Train Bit Regenerator and Remodulator

This block sits at the read end of a recirculating serial delay loop. The loop hands back each stored bit as an inverted burst of carrier pulses. After the trip these pulses are weak, and the last pulse of a burst is often cut short. The block turns each burst into one clean bit per bit slot and aligns that bit to the bit clock. It then gates the carrier with the bit again, so the next pass through the loop starts from a clean pulse train.

The block has no filter. Within a bit window, any low sample of the returned signal sets a capture flag. The flag is moved into the bit register and cleared on each rising edge of the bit clock. One surviving pulse is therefore enough to recover a 1. A host can replace the bit of the selected slot at the modulator input. The host does this by raising the write enable while the slot-select strobe is high.

All logic runs on a system clock at four times the carrier frequency. `carrier_i` and `bit_clk_i` are synchronous to this clock. In each bit period of 16 system cycles, the bit clock is high for the first 8 cycles. The carrier is high in cycles 1 and 2 of every group of four, so it is low in the cycle where the bit clock rises. The returned signal is asynchronous.

Top module: `pulse_regen`

## Requirements
- R1: `ret_raw_i` is active low and idles high. It passes through a two-stage synchronizer that resets to high. A low level that `ret_raw_i` holds for one system cycle c reaches the capture logic in cycle c+2.
- R2: A synchronized low sample that falls in a cycle with no bit clock rise sets the capture flag. The flag stays set until the next bit clock rise.
- R3: A bit clock rise is a cycle in which `bit_clk_i` is 1 after it was 0 in the previous cycle. On every rise the capture flag clears to 0.
- R4: On each rise, `regen_o` takes the flag OR'd with the synchronized sample of that same cycle. A window therefore takes raw lows from phase 15 of the previous period through phase 14 of this period. A window that holds one shortened pulse gives 1. An empty window gives 0.
- R5: `regen_o` changes only in the cycle after a bit clock rise. It stays stable for the rest of the slot.
- R6: `mod_o` is the combinational AND of `carrier_i` and the modulator bit. A 1 bit gives exactly four carrier pulses per slot, and a 0 bit gives none.
- R7: When `we_i` and `sel_i` are both 1, the modulator bit is `wdata_i`.
- R8: If `we_i` or `sel_i` is 0, the modulator bit is `regen_o` and `wdata_i` has no effect on `mod_o`.
- R9: While `rst_ni` is low, `regen_o` is 0 and the capture flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, four times the carrier |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Carrier, synchronous to clk_i |
| bit_clk_i | input | 1 | Bit clock, one quarter of the carrier |
| ret_raw_i | input | 1 | Returned pulse train, active low, asynchronous |
| sel_i | input | 1 | Slot-select strobe |
| we_i | input | 1 | Host write enable |
| wdata_i | input | 1 | Host write data |
| regen_o | output | 1 | Regenerated, retimed bit |
| mod_o | output | 1 | Remodulated drive signal |

## Verification
The bench sends random bursts of zero to four pulses, each burst starting at a random carrier position, with the last pulse cut to one cycle. These bursts show whether one weak pulse is enough to set the bit, and whether an empty slot clears it. Single pulses placed at phases 13, 14 and 15 locate the window edge as it lies after the synchronizer delay: a pulse at phase 14 must count in its own slot and a pulse at phase 15 in the next. The bench also mixes write cases: writes that invert the looped bit, and writes with only one of enable and select high. These show whether the host path overrides the recirculated bit, and whether it stays inert when it should. Every slot's carrier pulses at `mod_o` are counted to confirm four pulses per 1 and none per 0.

// File: rtl/regen_pkg.sv
`timescale 1ns/1ps
package regen_pkg;
  localparam int unsigned SyncStagesDef = 2;

  typedef enum logic {
    SRC_LOOP = 1'b0,
    SRC_HOST = 1'b1
  } mod_src_e;
endpackage

// File: rtl/regen_sync.sv
`timescale 1ns/1ps
module regen_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = pipe_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= RST_VAL;
      else         pipe_q[i] <= src;
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/regen_capture.sv
`timescale 1ns/1ps
module regen_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_clk_i,
  input  logic hit_i,
  output logic bit_o,
  output logic flag_o,
  output logic rise_o
);
  logic bclk_q, flag_q, bit_q;

  assign rise_o = bit_clk_i & ~bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      flag_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      bclk_q <= bit_clk_i;
      if (rise_o) begin
        // close the window: a hit in the rise cycle still counts
        bit_q  <= flag_q | hit_i;
        flag_q <= 1'b0;
      end else if (hit_i) begin
        flag_q <= 1'b1;
      end
    end
  end

  assign bit_o  = bit_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/regen_mod.sv
`timescale 1ns/1ps
module regen_mod
  import regen_pkg::*;
(
  input  logic carrier_i,
  input  logic sel_i,
  input  logic we_i,
  input  logic wdata_i,
  input  logic bit_i,
  output logic mod_o
);
  mod_src_e src;
  logic     mod_bit;

  assign src     = (we_i && sel_i) ? SRC_HOST : SRC_LOOP;
  assign mod_bit = (src == SRC_HOST) ? wdata_i : bit_i;
  assign mod_o   = carrier_i & mod_bit;
endmodule

// File: rtl/pulse_regen.sv
`timescale 1ns/1ps
module pulse_regen
  import regen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SyncStagesDef
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  input  logic bit_clk_i,
  input  logic ret_raw_i,
  input  logic sel_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic regen_o,
  output logic mod_o
);
  logic ret_s, hit_w, flag_w, rise_w, bit_w;

  regen_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ret_raw_i),
    .q_o   (ret_s)
  );

  assign hit_w = ~ret_s;

  regen_capture i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_clk_i(bit_clk_i),
    .hit_i    (hit_w),
    .bit_o    (bit_w),
    .flag_o   (flag_w),
    .rise_o   (rise_w)
  );

  regen_mod i_mod (
    .carrier_i(carrier_i),
    .sel_i    (sel_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .bit_i    (bit_w),
    .mod_o    (mod_o)
  );

  assign regen_o = bit_w;
endmodule

// File: rtl/pulse_regen_chk.sv
`timescale 1ns/1ps
module pulse_regen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic carrier_i,
  input logic bit_clk_i,
  input logic sel_i,
  input logic we_i,
  input logic wdata_i,
  input logic regen_o,
  input logic mod_o,
  input logic hit_i,
  input logic rise_i,
  input logic flag_i
);
  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !rise_i) |=> flag_i);

  // R3
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !flag_i);

  // R4
  capture_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && hit_i) |=> regen_o);

  // R5
  regen_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regen_o) |-> $past(rise_i));

  // R6
  mod_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |-> carrier_i);

  // R7
  host_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |-> (mod_o == (carrier_i & wdata_i)));

  // R8
  loop_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i) |-> (mod_o == (carrier_i & regen_o)));

  // R9
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (!regen_o && !flag_i);
    end
  end
endmodule

bind pulse_regen pulse_regen_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .carrier_i(carrier_i),
  .bit_clk_i(bit_clk_i),
  .sel_i    (sel_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .regen_o  (regen_o),
  .mod_o    (mod_o),
  .hit_i    (hit_w),
  .rise_i   (rise_w),
  .flag_i   (flag_w)
);

// File: tb/test_pulse_regen.sv
`timescale 1ns/1ps
module test_pulse_regen;
  logic clk = 1'b0;
  logic rst_n, carrier, bit_clk, ret_raw, sel, we, wdata;
  logic regen, mod_out;

  int checks = 0;
  int errors = 0;
  logic prev_bit = 1'b0;  // expected regen_o during the current slot
  logic carry    = 1'b0;  // phase-15 pulse belongs to the next slot
  logic done     = 1'b0;

  always #10 clk = ~clk;

  pulse_regen i_pulse_regen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .carrier_i(carrier),
    .bit_clk_i(bit_clk),
    .ret_raw_i(ret_raw),
    .sel_i    (sel),
    .we_i     (we),
    .wdata_i  (wdata),
    .regen_o  (regen),
    .mod_o    (mod_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // k pulses starting at carrier slot s, last one cut to one cycle
  function automatic logic [15:0] burst(input int k, input int s);
    logic [15:0] m = '0;
    for (int i = s; i < s + k; i++) begin
      m[1+4*i] = 1'b1;
      if (i != s + k - 1) m[2+4*i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic exp_mod_bit(input logic w, input logic s, input logic d, input logic lp);
    return (w && s) ? d : lp;
  endfunction

  task automatic run_slot(input logic [15:0] low_mask, input logic s_sel, input logic s_we,
                          input logic s_wd, input string tag);
    logic mbit, last, r4;
    int   rises;
    mbit  = exp_mod_bit(s_we, s_sel, s_wd, prev_bit);
    last  = 1'b0;
    rises = 0;
    r4    = 1'b0;
    for (int p = 0; p < 16; p++) begin
      bit_clk = (p < 8);
      carrier = ((p % 4) == 1) || ((p % 4) == 2);
      ret_raw = ~low_mask[p];
      sel = s_sel; we = s_we; wdata = s_wd;
      @(posedge clk);
      #5;
      if (mod_out && !last) rises++;
      last = mod_out;
      if (p == 4) begin
        check({"R4 ", tag}, {7'd0, regen}, {7'd0, prev_bit});
        r4 = regen;
      end
      if (p == 15) check({"R5 ", tag}, {7'd0, regen}, {7'd0, r4});
      @(negedge clk);
    end
    check({"R6 ", tag}, 8'(rises), mbit ? 8'd4 : 8'd0);
    prev_bit = (|low_mask[14:0]) | carry;
    carry    = low_mask[15];
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    rst_n = 1'b0; carrier = 1'b0; bit_clk = 1'b0; ret_raw = 1'b1;
    sel = 1'b0; we = 1'b0; wdata = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    check("R9 reset regen", {7'd0, regen}, 8'd0);
    check("R9 reset mod", {7'd0, mod_out}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_slot('0, 1'b0, 1'b0, 1'b0, "empty after reset");
    run_slot(16'h2000, 1'b0, 1'b0, 1'b0, "R1 single short pulse phase 13");
    run_slot('0, 1'b0, 1'b0, 1'b0, "R2 empty");
    run_slot(16'h4000, 1'b0, 1'b0, 1'b0, "edge pulse phase 14");
    run_slot(16'h8000, 1'b0, 1'b0, 1'b0, "edge pulse phase 15");
    run_slot('0, 1'b0, 1'b0, 1'b0, "R3 carried into slot");
    run_slot(burst(4, 0), 1'b0, 1'b0, 1'b0, "full burst");
    run_slot('0, 1'b1, 1'b1, 1'b0, "R7 write 0 over 1");
    run_slot('0, 1'b1, 1'b1, 1'b1, "R7 write 1 over 0");
    run_slot(burst(1, 3), 1'b0, 1'b1, 1'b1, "R8 we only");
    run_slot('0, 1'b1, 1'b0, 1'b0, "R8 sel only");

    for (int n = 0; n < 300; n++) begin
      int          k, s, mode;
      logic [15:0] m;
      logic        ws, ww, wd;
      k    = $urandom_range(0, 4);
      s    = (k == 0) ? 0 : $urandom_range(0, 4 - k);
      m    = burst(k, s);
      mode = $urandom_range(0, 7);
      ws = (mode == 4) || (mode == 6);
      ww = (mode == 4) || (mode == 5);
      wd = 1'($urandom_range(0, 1));
      if (mode == 7) m[15] = 1'b1;
      run_slot(m, ws, ww, wd, "random burst");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule